// File: doc/BRIEF.md
# Byte-Link Receiver with Acknowledge Flow Control

This block is the receiving end of a source-synchronous, byte-wide link. The remote transmitter drives an 8-bit data bus together with its own link clock. The receiver drives an acknowledge line back to the transmitter. The receiver oversamples the link clock and data with its local clock, through a two-flop synchronizer. It takes one byte on each detected falling edge of the link clock. Four bytes are packed into a 32-bit word, with the first byte in the lowest bits. The word is then pushed into a two-word buffer, which local logic drains through a valid/ready read port.

The acknowledge line throttles the sender one word at a time. The transmitter checks acknowledge before it starts a word, and it always finishes a word once started. The receiver lowers acknowledge only on the rising link-clock edge that follows the first byte of a word, and only when that word will take the last free slot. While more room remains, the sender never sees acknowledge low. A local enable switches the port on with a fixed two-cycle latency. While disabled, the port drops acknowledge, ignores link activity and forgets any partially received word.

Top module: `link_rx_port`

## Requirements
- R1: After reset, `lnk_ack` and `rd_valid` are both 0.
- R2: Four received bytes form one word on `rd_data`. The first byte is in bits 7:0 and the fourth byte is in bits 31:24. Words leave in arrival order. A word is consumed at a clock edge where `rd_valid` and `rd_ready` are both 1, and `rd_data` stays stable while `rd_ready` is 0.
- R3: A byte is taken from `lnk_dat` only on a high-to-low transition of `lnk_clk`. Values that the bus holds while `lnk_clk` is high are not captured.
- R4: Suppose `enable` is raised just before clock edge k, with an empty buffer. Then `lnk_ack` is still 0 after edges k and k+1 and becomes 1 after edge k+2.
- R5: While the port is inactive, `lnk_ack` is 0 and link transfers are neither captured nor counted. On re-enable, assembly restarts at the first byte of a word.
- R6: If a word starts while at least two slots are free, `lnk_ack` stays 1 throughout that word.
- R7: `lnk_ack` goes low only in response to the rising link-clock edge that follows the first byte of a word, and only when that word will occupy the last free slot. It is still 1 just before that rising edge.
- R8: While the buffer is full, `lnk_ack` stays 0. One clock after a read frees a slot between words, `lnk_ack` returns to 1.
- R9: A word completing in the same cycle as a read keeps the buffer count and order intact: the read returns the older word and the new word remains readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable, active high |
| lnk_clk | input | 1 | Link clock from the transmitter |
| lnk_dat | input | 8 | Link data byte |
| lnk_ack | output | 1 | Acknowledge to the transmitter; 1 means another word may start |
| rd_data | output | 32 | Oldest buffered word |
| rd_valid | output | 1 | Buffer holds at least one word |
| rd_ready | input | 1 | Local consumer takes the word on this edge |

## Verification
Two events can land on the same local clock edge: the push of a completed word into the buffer, and a read that pops a word from it. To provoke the collision, one word is pre-loaded first. The read strobe of the following word is then swept across the four clock edges after its last link-clock fall, so that one position coincides exactly with the push and the others fall just before or just after it. Each position is judged from the ports. The strobed read must return the older word, exactly one further word (the newer one) must remain, and the buffer must then be empty.

// File: rtl/link_rx_port.sv
module link_rx_port #(
  parameter int BYTES_PER_WORD = 4,
  parameter int DEPTH = 2,
  localparam int WW = 8 * BYTES_PER_WORD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          lnk_clk,
  input  logic [7:0]    lnk_dat,
  output logic          lnk_ack,
  output logic [WW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_ready
);
  localparam int CW = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST  = CW'(BYTES_PER_WORD - 1);
  localparam logic [CW-1:0] FIRST = CW'(1);
  localparam logic [NW-1:0] FULL  = NW'(DEPTH);
  localparam logic [NW-1:0] NEAR  = NW'(DEPTH - 1);
  localparam logic [AW-1:0] ALAST = AW'(DEPTH - 1);

  logic          en_d1, en_act;
  logic          lc_s1, lc_s2, lc_prev;
  logic [7:0]    ld_s1, ld_s2;
  logic [CW-1:0] cnt;
  logic [WW-1:0] asm_q, asm_nx;
  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [NW-1:0] count;
  logic          ack_q, ack_nx;

  wire fall = en_act & lc_prev & ~lc_s2;
  wire rise = en_act & ~lc_prev & lc_s2;
  wire push = fall && (cnt == LAST);
  wire pop  = rd_valid && rd_ready;

  assign rd_valid = (count != '0);
  assign rd_data  = mem[rd_ptr];
  assign lnk_ack  = ack_q;

  always_comb begin
    asm_nx = asm_q;
    asm_nx[cnt*8 +: 8] = ld_s2;
  end

  always_comb begin
    ack_nx = ack_q;
    if (!en_act)
      ack_nx = 1'b0;
    else if (rise && cnt == FIRST && count >= NEAR)
      ack_nx = 1'b0;
    else if (!ack_q && cnt == '0 && count < FULL)
      ack_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d1   <= 1'b0;
      en_act  <= 1'b0;
      lc_s1   <= 1'b0;
      lc_s2   <= 1'b0;
      lc_prev <= 1'b0;
      ld_s1   <= '0;
      ld_s2   <= '0;
      cnt     <= '0;
      asm_q   <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ack_q   <= 1'b0;
    end else begin
      en_d1   <= enable;
      en_act  <= en_d1;
      lc_s1   <= lnk_clk;
      lc_s2   <= lc_s1;
      lc_prev <= lc_s2;
      ld_s1   <= lnk_dat;
      ld_s2   <= ld_s1;
      ack_q   <= ack_nx;
      if (!en_act)
        cnt <= '0;
      else if (fall)
        cnt <= push ? '0 : cnt + FIRST;
      if (fall)
        asm_q <= asm_nx;
      if (push)
        wr_ptr <= (wr_ptr == ALAST) ? '0 : wr_ptr + AW'(1);
      if (pop)
        rd_ptr <= (rd_ptr == ALAST) ? '0 : rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + NW'(1);
        2'b01:   count <= count - NW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push)
      mem[wr_ptr] <= asm_nx;
  end

  assert_ack_low_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> !lnk_ack);

  assert_enable_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnk_ack) |-> $past(enable, 3));

  assert_ack_drop_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lnk_ack) && $past(en_act)) |-> ($past(rise) && $past(cnt) == FIRST));

  assert_full_blocks_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL) |-> !lnk_ack);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != FULL || pop));
endmodule

// File: tb/tb_link_rx_port.sv
`timescale 1ns/1ps
module tb_link_rx_port;
  logic        clk = 1'b0;
  logic        rst_n, enable, lnk_clk, rd_ready;
  logic [7:0]  lnk_dat;
  logic        lnk_ack, rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] popped;
  logic ack_b0, ack_end;

  always #2.5 clk = ~clk;

  link_rx_port dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .lnk_clk(lnk_clk),
    .lnk_dat(lnk_dat), .lnk_ack(lnk_ack), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int pop_at);
    lnk_clk = 1'b1;
    lnk_dat = ~b;
    repeat (2) @(negedge clk);
    lnk_dat = b;
    repeat (2) @(negedge clk);
    lnk_clk = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i == pop_at) begin
        popped = rd_data;
        rd_ready = 1'b1;
      end else begin
        rd_ready = 1'b0;
      end
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input int pop_at);
    while (!lnk_ack) @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      send_byte(w[8*b +: 8], (b == 3) ? pop_at : -1);
      if (b == 0) ack_b0 = lnk_ack;
    end
    ack_end = lnk_ack;
  endtask

  task automatic read_word(input string tag, input logic [31:0] exp);
    chk({tag, " valid"}, {31'b0, rd_valid}, 32'd1);
    chk({tag, " data"}, rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ack after reset", {31'b0, lnk_ack}, 32'd0);
    chk("R1 valid after reset", {31'b0, rd_valid}, 32'd0);
  endtask

  task automatic t_enable;
    enable = 1'b1;
    @(negedge clk);
    chk("R4 ack after edge k", {31'b0, lnk_ack}, 32'd0);
    @(negedge clk);
    chk("R4 ack after edge k+1", {31'b0, lnk_ack}, 32'd0);
    @(negedge clk);
    chk("R4 ack after edge k+2", {31'b0, lnk_ack}, 32'd1);
  endtask

  task automatic t_basic;
    send_word(32'h11223344, -1);
    repeat (3) @(negedge clk);
    chk("R2 data held without ready", rd_data, 32'h11223344);
    read_word("R2 R3 byte order", 32'h11223344);
    chk("R2 empty after read", {31'b0, rd_valid}, 32'd0);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 5; i++) begin
      logic [31:0] w;
      w = 32'hA5C30F00 + i * 32'h01030507;
      send_word(w, -1);
      chk("R6 ack after first byte", {31'b0, ack_b0}, 32'd1);
      chk("R6 ack at word end", {31'b0, ack_end}, 32'd1);
      read_word("R2 stream", w);
    end
  endtask

  task automatic t_fill;
    send_word(32'hCAFE0001, -1);
    chk("R6 ack one word buffered", {31'b0, ack_end}, 32'd1);
    send_word(32'hBEEF0002, -1);
    chk("R7 ack kept before second rise", {31'b0, ack_b0}, 32'd1);
    chk("R7 ack dropped by word end", {31'b0, ack_end}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R8 ack low while full", {31'b0, lnk_ack}, 32'd0);
    read_word("R2 fill first", 32'hCAFE0001);
    chk("R8 ack not yet back", {31'b0, lnk_ack}, 32'd0);
    @(negedge clk);
    chk("R8 ack back after read", {31'b0, lnk_ack}, 32'd1);
    read_word("R2 fill second", 32'hBEEF0002);
  endtask

  task automatic t_disable;
    send_byte(8'h5A, -1);
    send_byte(8'h6B, -1);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 ack low when disabled", {31'b0, lnk_ack}, 32'd0);
    for (int i = 0; i < 4; i++) send_byte(8'hE0 + 8'(i), -1);
    chk("R5 nothing captured when disabled", {31'b0, rd_valid}, 32'd0);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 ack after re-enable", {31'b0, lnk_ack}, 32'd1);
    send_word(32'h0D0C0B0A, -1);
    read_word("R5 counter restarted", 32'h0D0C0B0A);
    chk("R5 single word only", {31'b0, rd_valid}, 32'd0);
  endtask

  task automatic t_coincide;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] wa, wb;
      wa = 32'h10000000 + 32'(k);
      wb = 32'h20000000 + 32'(k);
      send_word(wa, -1);
      send_word(wb, k);
      chk("R9 strobed read returns older", popped, wa);
      read_word("R9 newer remains", wb);
      chk("R9 empty afterwards", {31'b0, rd_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    enable = 1'b0;
    lnk_clk = 1'b0;
    lnk_dat = 8'h00;
    rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_enable;
    t_basic;
    t_stream;
    t_fill;
    t_disable;
    t_coincide;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule